// File: doc/BRIEF.md
# Capture Compare PWM Timer

An up-counting timer with two capture channels, two compare channels and a PWM mode. The counter advances on a tick. The tick comes either from a power-of-two divider on the system clock or from rising edges of an external clock pin. Capture pins latch the running count on an edge the user selects. Compare registers drive a single output pin. In PWM mode the two compare registers together set the period and the duty of one waveform.

Every event sets a sticky status flag. Software clears a flag by writing 1 to its bit. A single interrupt line is the OR of the enabled pending flags. It stays high until all of them are cleared or disabled. Configuration and status go through a small register port. Writes happen on `reg_wr` at the clock edge. Reads are combinational from `reg_addr`.

Register map, one word per address. Each word is `CNT_W` bits wide, and `CNT_W` must be at least 12:

| Addr | Register | Content |
|---|---|---|
| 0 | control | bit0 run, bit1 external tick, bits4:2 divider exponent n, bit5 PWM, bits7:6 capture 0 edge, bits9:8 capture 1 edge, bit10 level for match A, bit11 level for match B |
| 1 | interrupt enable | same bit layout as status |
| 2 | status | bit0 wrap, bit1 capture 0, bit2 capture 1, bit3 match A, bit4 match B |
| 3 | count | read the count, or write to load it |
| 4 | compare A | |
| 5 | compare B | |
| 6 | capture 0 | read only |
| 7 | capture 1 | read only |

The capture edge codes are: 00 off, 01 rising, 10 falling, 11 both.

Top module: `ccp_timer`

## Requirements
- R1: After reset, all registers read 0, `cmp_out` is 0 and `irq` is 0.
- R2: With run=1 and external tick=0, the count advances once every 2^n clock cycles. A write to the count register restarts the divider, so K clock edges after that write the count equals K>>n.
- R3: When a tick finds the count at its maximum value outside a PWM period reset, the count wraps to 0 and status bit0 is set.
- R4: With external tick=1, each rising edge of `ext_clk` advances the count by one. The edge passes a two-flop synchronizer first.
- R5: A capture channel latches the count and sets its status bit (bit1 for channel 0, bit2 for channel 1) only on the edge its 2-bit code selects. With code 00 the channel's register and flag do not change.
- R6: Outside PWM mode, a tick with the count equal to compare A drives `cmp_out` to the level in bit10. A tick with the count equal to compare B drives it to the level in bit11. Match B wins when both match.
- R7: In PWM mode, a match with A resets the count to 0 and drives `cmp_out` high, and a match with B drives it low. With A=9 and B=3 the output is high for 4 of every 10 ticks, and the count never exceeds 9.
- R8: `irq` is high exactly while some status bit and its enable bit are both 1. Writing 1 to a status bit clears only that bit, and a new event in the same cycle wins over the clear.
- R9: A write to the count register loads the value and takes precedence over a tick in that cycle. With run=0 the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| ext_clk | input | 1 | External tick source, asynchronous |
| cap_in | input | 2 | Capture pins, asynchronous |
| cmp_out | output | 1 | Compare / PWM output pin |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench builds the timer with its defaults: a 16-bit counter, a 3-bit divider exponent and a two-stage synchronizer. Divider exponents 0, 2 and 3 are exercised with exact expected counts, which is possible because a count write restarts the divider. Wrap is reached in two ticks by loading the count just below its maximum. The PWM waveform is measured over whole periods with a period of 10 and a duty of 4.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NCAP   = 2;
  localparam int unsigned FLAG_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAP0 = 3'd6;
  localparam logic [ADDR_W-1:0] A_CAP1 = 3'd7;

  localparam int unsigned F_WRAP = 0;
  localparam int unsigned F_CAP0 = 1;
  localparam int unsigned F_MA   = 3;
  localparam int unsigned F_MB   = 4;

  typedef struct packed {
    logic       lvl_b;
    logic       lvl_a;
    logic [1:0] edge1;
    logic [1:0] edge0;
    logic       pwm;
    logic [2:0] dexp;
    logic       ext;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/ccp_sync.sv
module ccp_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= din;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= stg_q[STAGES-1];
  end

  assign rise = stg_q[STAGES-1] & ~prev_q;
  assign fall = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ccp_prescale.sv
module ccp_prescale #(
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ext_sel,
  input  logic             ext_rise,
  input  logic             restart,
  input  logic [PSC_W-1:0] dexp,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, mask;
  logic             div_en;

  assign mask   = DIV_W'((1 << dexp) - 1);
  assign div_en = run & ~ext_sel;

  always_comb begin
    div_d = div_q;
    if (restart)     div_d = '0;
    else if (div_en) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick = run & (ext_sel ? ext_rise : ((div_q & mask) == mask));
endmodule

// File: rtl/ccp_timer.sv
module ccp_timer
  import ccp_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PSC_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              ext_clk,
  input  logic [1:0]        cap_in,
  output logic              cmp_out,
  output logic              irq
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctrl_t             ctrl_q;
  logic [FLAG_W-1:0] ien_q, stat_q, stat_d, set_v, clr_v;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cmpa_q, cmpb_q;
  logic [CNT_W-1:0]  cap_q [NCAP];
  logic              out_q, out_d;
  logic              tick_w, wrap_w, match_a, match_b;
  logic [NCAP:0]     rise_w, fall_w;
  logic [NCAP-1:0]   cap_hit;
  logic              wr_ctrl, wr_ien, wr_stat, wr_cnt, wr_cmpa, wr_cmpb;

  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign wr_ien  = reg_wr && reg_addr == A_IEN;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign wr_cnt  = reg_wr && reg_addr == A_CNT;
  assign wr_cmpa = reg_wr && reg_addr == A_CMPA;
  assign wr_cmpb = reg_wr && reg_addr == A_CMPB;

  ccp_sync #(.WIDTH(NCAP+1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cap_in, ext_clk}),
    .rise(rise_w), .fall(fall_w)
  );

  ccp_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .ext_sel(ctrl_q.ext),
    .ext_rise(rise_w[0]), .restart(wr_cnt), .dexp(ctrl_q.dexp[PSC_W-1:0]),
    .tick(tick_w)
  );

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    logic [1:0] esel;
    assign esel = (i == 0) ? ctrl_q.edge0 : ctrl_q.edge1;
    assign cap_hit[i] = (esel[0] & rise_w[i+1]) | (esel[1] & fall_w[i+1]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_q[i] <= '0;
      else if (cap_hit[i]) cap_q[i] <= cnt_q;
    end
  end

  assign match_a = tick_w && cnt_q == cmpa_q;
  assign match_b = tick_w && cnt_q == cmpb_q;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_w = 1'b0;
    if (wr_cnt) begin
      cnt_d = reg_wdata;
    end else if (tick_w) begin
      if (ctrl_q.pwm && match_a) begin
        cnt_d = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        wrap_w = (cnt_q == CNT_MAX);
      end
    end
  end

  always_comb begin
    out_d = out_q;
    if (match_b)      out_d = ctrl_q.pwm ? 1'b0 : ctrl_q.lvl_b;
    else if (match_a) out_d = ctrl_q.pwm ? 1'b1 : ctrl_q.lvl_a;
  end

  assign set_v  = {match_b, match_a, cap_hit, wrap_w};
  assign clr_v  = wr_stat ? reg_wdata[FLAG_W-1:0] : '0;
  assign stat_d = (stat_q & ~clr_v) | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      stat_q <= '0;
      cnt_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      out_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (wr_ien)  ien_q  <= reg_wdata[FLAG_W-1:0];
      if (wr_cmpa) cmpa_q <= reg_wdata;
      if (wr_cmpb) cmpb_q <= reg_wdata;
      stat_q <= stat_d;
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = CNT_W'(ctrl_q);
      A_IEN:   reg_rdata = CNT_W'(ien_q);
      A_STAT:  reg_rdata = CNT_W'(stat_q);
      A_CNT:   reg_rdata = cnt_q;
      A_CMPA:  reg_rdata = cmpa_q;
      A_CMPB:  reg_rdata = cmpb_q;
      A_CAP0:  reg_rdata = cap_q[0];
      default: reg_rdata = cap_q[1];
    endcase
  end

  assign cmp_out = out_q;
  assign irq     = |(stat_q & ien_q);
endmodule

// File: rtl/ccp_timer_chk.sv
module ccp_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             irq,
  input logic             tick,
  input logic             pwm,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmpa,
  input logic [4:0]       stat,
  input logic [1:0]       cap_hit
);
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq); // R8
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !tick) |=> $stable(cnt)); // R2
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reg_wr && !pwm && cnt == {CNT_W{1'b1}}) |=> (stat[0] && cnt == '0)); // R3
  AST_PWM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reg_wr && pwm && cnt == cmpa) |=> cnt == '0); // R7
  AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit[0] |=> stat[1]); // R5
endmodule

bind ccp_timer ccp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .irq(irq), .tick(tick_w),
  .pwm(ctrl_q.pwm), .cnt(cnt_q), .cmpa(cmpa_q), .stat(stat_q), .cap_hit(cap_hit)
);

// File: tb/test_ccp_timer.sv
module test_ccp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ext_clk = 1'b0;
  logic [1:0]  cap_in = '0;
  logic        cmp_out, irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ccp_timer i_ccp_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
    .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    reg_addr = a; #0.5;
    v = int'(reg_rdata);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 register reset", v, 0);
    end
    check("R1 cmp_out reset", int'(cmp_out), 0);
    check("R1 irq reset", int'(irq), 0);
  endtask

  task automatic t_prescale(input int n, input int k);
    int v;
    wr(3'd0, 16'(1 | (n << 2)));
    wr(3'd3, 16'd0);
    repeat (k) @(posedge clk);
    rd(3'd3, v);
    check("R2 divided count", v, k >> n);
  endtask

  task automatic t_wrap();
    int v;
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h001F);
    wr(3'd3, 16'hFFFE);
    rd(3'd3, v);
    check("R9 load while stopped", v, 16'hFFFE);
    repeat (5) @(posedge clk);
    rd(3'd3, v);
    check("R9 stopped count holds", v, 16'hFFFE);
    wr(3'd0, 16'h0001);
    wr(3'd3, 16'hFFFE);
    repeat (2) @(posedge clk);
    wr(3'd0, 16'h0000);
    rd(3'd3, v);
    check("R3 wrapped count", v, 1);
    rd(3'd2, v);
    check("R3 wrap flag", v & 1, 1);
    check("R8 irq off while disabled", int'(irq), 0);
  endtask

  task automatic t_ext();
    int v;
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'd0);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk) ext_clk = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(posedge clk);
    rd(3'd3, v);
    check("R4 external edges counted", v, 5);
  endtask

  task automatic t_capture();
    int v;
    wr(3'd0, 16'h0240);
    wr(3'd3, 16'h1234);
    wr(3'd2, 16'h001F);
    @(negedge clk) cap_in = 2'b11;
    repeat (6) @(posedge clk);
    rd(3'd6, v);
    check("R5 rising capture", v, 16'h1234);
    rd(3'd2, v);
    check("R5 cap0 flag", (v >> 1) & 1, 1);
    check("R5 cap1 ignores rising", (v >> 2) & 1, 0);
    rd(3'd7, v);
    check("R5 cap1 unchanged on rising", v, 0);
    @(negedge clk) cap_in = 2'b00;
    repeat (6) @(posedge clk);
    rd(3'd7, v);
    check("R5 falling capture", v, 16'h1234);
    rd(3'd2, v);
    check("R5 cap1 flag", (v >> 2) & 1, 1);
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0042);
    wr(3'd2, 16'h001F);
    @(negedge clk) cap_in = 2'b01;
    repeat (6) @(posedge clk);
    @(negedge clk) cap_in = 2'b00;
    repeat (6) @(posedge clk);
    rd(3'd6, v);
    check("R5 disabled channel holds", v, 16'h1234);
    rd(3'd2, v);
    check("R5 disabled channel no flag", v, 0);
  endtask

  task automatic t_irq();
    int v;
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0040);
    wr(3'd3, 16'hFFFE);
    wr(3'd0, 16'h0041);
    wr(3'd3, 16'hFFFE);
    repeat (2) @(posedge clk);
    wr(3'd0, 16'h0040);
    @(negedge clk);
    check("R8 irq low with flag disabled", int'(irq), 0);
    wr(3'd1, 16'h0003);
    @(negedge clk);
    check("R8 irq on enabled flag", int'(irq), 1);
    @(negedge clk) cap_in = 2'b01;
    repeat (6) @(posedge clk);
    @(negedge clk) cap_in = 2'b00;
    wr(3'd2, 16'h0001);
    rd(3'd2, v);
    check("R8 w1c clears one bit", v & 3, 2);
    check("R8 irq held by other flag", int'(irq), 1);
    wr(3'd2, 16'h0002);
    @(negedge clk);
    check("R8 irq drops when all clear", int'(irq), 0);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_compare();
    wr(3'd4, 16'd10);
    wr(3'd5, 16'd20);
    wr(3'd0, 16'h0401);
    wr(3'd3, 16'd0);
    repeat (15) @(posedge clk);
    @(negedge clk);
    check("R6 match A level high", int'(cmp_out), 1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R6 match B level low", int'(cmp_out), 0);
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'd10);
    wr(3'd0, 16'h0401);
    wr(3'd3, 16'd0);
    repeat (15) @(posedge clk);
    @(negedge clk);
    check("R6 match B wins on tie", int'(cmp_out), 0);
  endtask

  task automatic t_pwm();
    int high = 0;
    int over = 0;
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'd9);
    wr(3'd5, 16'd3);
    wr(3'd0, 16'h0021);
    wr(3'd3, 16'd0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    reg_addr = 3'd3;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk); #0.5;
      if (cmp_out) high++;
      if (reg_rdata > 16'd9) over++;
    end
    check("R7 duty high cycles", high, 40);
    check("R7 count bounded by A", over, 0);
    wr(3'd0, 16'h0000);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_prescale(0, 37);
    t_prescale(2, 41);
    t_prescale(3, 64);
    t_wrap();
    t_ext();
    t_capture();
    t_irq();
    t_compare();
    t_pwm();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule